// File: doc/BRIEF.md
# Pushbutton LED Charge Bar Display

This block drives a short LED bar graph that shows how much charge a battery has left. The bar is dark until someone presses an active-low pushbutton. A press lights the bar for a fixed window of a few seconds. Each lit segment stands for an equal share of full charge. Three, four or five segments can be configured, so each segment is worth about 33%, 25% or 20%.

The value shown is either the relative percentage (measured against the learned full capacity) or the absolute percentage (measured against the design capacity). One mode bit picks which. When a low-capacity alarm is raised, the lit segments flash at 1 Hz. When the end-of-discharge flag is raised, the bar stays dark whatever the button does.

Timing comes from a free-running tick input that pulses `TICK_HZ` times per second. The button passes through a two-flop synchronizer. Apart from that, the block does no debouncing. All other inputs are plain levels that the surrounding logic keeps up to date.

Top module: `charge_bar_display`

## Requirements
- R1: `seg_cfg` sets the bar length: 2'b00 gives 3 segments, 2'b01 gives 4, and 2'b10 or 2'b11 gives 5. LED index 0 is the lowest segment.
- R2: While the bar is shown, the number of lit segments is ceil(pct × N / 100), where N is the bar length. 0% lights none, 1% lights one, and the lit segments are always the lowest indices.
- R3: `use_abs` = 0 shows `soc_rel`; `use_abs` = 1 shows `soc_abs`.
- R4: After reset the bar is dark and armed. With no falling edge on `btn_n` it stays dark.
- R5: A falling edge on `btn_n` while armed lights the bar within 4 clock cycles. The bar stays lit for `DISPLAY_SEC` × `TICK_HZ` tick pulses, then goes dark.
- R6: A falling edge during the window is ignored and does not extend the window. After the window, a new activation needs `btn_n` to go high and then fall again.
- R7: While `cap_alarm` is high, the lit segments flash. They are lit for `TICK_HZ`/2 ticks and dark for `TICK_HZ`/2 ticks, starting lit at activation.
- R8: While `eod_flag` is high, every LED output is high (off).
- R9: A percentage above 100 is treated as 100.
- R10: LED outputs above the configured bar length are always off. LED outputs are active low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| btn_n | input | 1 | Active-low pushbutton, asynchronous |
| tick | input | 1 | One-cycle pulse, `TICK_HZ` per second |
| soc_rel | input | PCT_W | Relative state of charge in percent |
| soc_abs | input | PCT_W | Absolute state of charge in percent |
| use_abs | input | 1 | 1 selects the absolute percentage |
| seg_cfg | input | 2 | Bar length selection |
| cap_alarm | input | 1 | Low-capacity alarm, makes the bar flash |
| eod_flag | input | 1 | End-of-discharge, blanks the bar |
| led_n | output | 5 | Active-low segment drives |

## Verification
The bar-level mapping is tried at 0, 1, 20, 21, 33, 34, 50, 100 and 120 percent, across all three bar lengths and both reference modes. These values separate ceiling from floor rounding, reveal a missing clamp, and show whether the mode bit picks the right source. The button is tested with a second press inside the window, with the button held low past the window's end, and with a clean release followed by a press. Together these tell a one-shot window apart from a retriggerable one and an edge-armed detector apart from a level-sensitive one. Flash phases are sampled mid-phase, so the lit and dark halves are each confirmed.

// File: rtl/cbd_pkg.sv
package cbd_pkg;
  localparam int LED_W = 5;
  localparam int CNT_W = 3;

  function automatic logic [CNT_W-1:0] bar_len(input logic [1:0] cfg);
    case (cfg)
      2'b00:   bar_len = 3'd3;
      2'b01:   bar_len = 3'd4;
      default: bar_len = 3'd5;
    endcase
  endfunction
endpackage

// File: rtl/cbd_btn_edge.sv
module cbd_btn_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic btn_n,
  output logic btn_hi,
  output logic btn_fall
);
  logic s1_q, s2_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      s1_q   <= btn_n;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign btn_hi   = s2_q;
  assign btn_fall = prev_q & ~s2_q;
endmodule

// File: rtl/cbd_window.sv
module cbd_window #(
  parameter int WIN_TICKS = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic btn_hi,
  input  logic btn_fall,
  output logic active,
  output logic start
);
  localparam int WW = $clog2(WIN_TICKS + 1);

  logic          armed_q;
  logic          active_q;
  logic [WW-1:0] cnt_q;

  assign start  = armed_q & btn_fall;
  assign active = active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q  <= 1'b1;
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (start) begin
      armed_q  <= 1'b0;
      active_q <= 1'b1;
      cnt_q    <= '0;
    end else begin
      if (!active_q && btn_hi) armed_q <= 1'b1;
      if (active_q && tick) begin
        if (cnt_q == WW'(WIN_TICKS - 1)) begin
          active_q <= 1'b0;
          cnt_q    <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assert_arm_needed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active_q) |-> $past(armed_q));
  assert_hold_no_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !tick) |=> active_q);
  assert_disarm_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active_q) |-> !armed_q);
endmodule

// File: rtl/cbd_blink.sv
module cbd_blink #(
  parameter int TICK_HZ = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic start,
  input  logic active,
  output logic phase_on
);
  localparam int HALF = (TICK_HZ / 2 < 1) ? 1 : TICK_HZ / 2;
  localparam int BW   = $clog2(HALF + 1);

  logic [BW-1:0] bcnt_q;
  logic          on_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt_q <= '0;
      on_q   <= 1'b1;
    end else if (start) begin
      bcnt_q <= '0;
      on_q   <= 1'b1;
    end else if (active && tick) begin
      if (bcnt_q == BW'(HALF - 1)) begin
        bcnt_q <= '0;
        on_q   <= ~on_q;
      end else begin
        bcnt_q <= bcnt_q + 1'b1;
      end
    end
  end

  assign phase_on = on_q;

  assert_flip_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && active && tick && bcnt_q == BW'(HALF - 1)) |=> (on_q != $past(on_q)));
  assert_steady_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !tick) |=> $stable(on_q));
endmodule

// File: rtl/cbd_level.sv
module cbd_level #(
  parameter int PCT_W = 7
) (
  input  logic [PCT_W-1:0]         pct,
  input  logic [cbd_pkg::CNT_W-1:0] nseg,
  output logic [cbd_pkg::LED_W-1:0] lit
);
  import cbd_pkg::*;
  localparam int PW = 10;

  logic [6:0]       pct_c;
  logic [PW-1:0]    prod;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    pct_c = (pct > PCT_W'(100)) ? 7'd100 : 7'(pct);
    prod  = PW'(pct_c) * PW'(nseg) + PW'(99);
    cnt   = CNT_W'(prod / PW'(100));
  end

  for (genvar g = 0; g < LED_W; g++) begin : g_seg
    assign lit[g] = (CNT_W'(g) < cnt) && (CNT_W'(g) < nseg);
  end
endmodule

// File: rtl/charge_bar_display.sv
module charge_bar_display #(
  parameter int PCT_W       = 7,
  parameter int TICK_HZ     = 8,
  parameter int DISPLAY_SEC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             btn_n,
  input  logic             tick,
  input  logic [PCT_W-1:0] soc_rel,
  input  logic [PCT_W-1:0] soc_abs,
  input  logic             use_abs,
  input  logic [1:0]       seg_cfg,
  input  logic             cap_alarm,
  input  logic             eod_flag,
  output logic [4:0]       led_n
);
  import cbd_pkg::*;
  localparam int WIN_TICKS = DISPLAY_SEC * TICK_HZ;

  logic             btn_hi, btn_fall, active, start, phase_on, show;
  logic [CNT_W-1:0] nseg;
  logic [LED_W-1:0] lit;

  cbd_btn_edge u_edge (
    .clk(clk), .rst_n(rst_n), .btn_n(btn_n), .btn_hi(btn_hi), .btn_fall(btn_fall)
  );

  cbd_window #(.WIN_TICKS(WIN_TICKS)) u_win (
    .clk(clk), .rst_n(rst_n), .tick(tick), .btn_hi(btn_hi), .btn_fall(btn_fall),
    .active(active), .start(start)
  );

  cbd_blink #(.TICK_HZ(TICK_HZ)) u_blink (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start(start), .active(active),
    .phase_on(phase_on)
  );

  assign nseg = bar_len(seg_cfg);

  cbd_level #(.PCT_W(PCT_W)) u_lvl (
    .pct(use_abs ? soc_abs : soc_rel), .nseg(nseg), .lit(lit)
  );

  assign show  = active & ~eod_flag & (~cap_alarm | phase_on);
  assign led_n = ~(lit & {LED_W{show}});

  assert_dark_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (&led_n));
  assert_within_len_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~led_n) <= int'(nseg));
  assert_eod_blank_R8: assert property (@(posedge clk) disable iff (!rst_n)
    eod_flag |-> (&led_n));
endmodule

// File: tb/charge_bar_display_test.sv
module charge_bar_display_test;
  localparam int TICK_HZ = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       btn_n = 1'b1;
  logic       tick = 1'b0;
  logic [6:0] soc_rel = 7'd50;
  logic [6:0] soc_abs = 7'd0;
  logic       use_abs = 1'b0;
  logic [1:0] seg_cfg = 2'b10;
  logic       cap_alarm = 1'b0;
  logic       eod_flag = 1'b0;
  logic [4:0] led_n;

  typedef struct {
    logic [4:0] exp;
    string      tag;
  } sb_item_t;

  sb_item_t sb[$];
  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  charge_bar_display #(.PCT_W(7), .TICK_HZ(TICK_HZ), .DISPLAY_SEC(4)) uut (
    .clk(clk), .rst_n(rst_n), .btn_n(btn_n), .tick(tick), .soc_rel(soc_rel),
    .soc_abs(soc_abs), .use_abs(use_abs), .seg_cfg(seg_cfg), .cap_alarm(cap_alarm),
    .eod_flag(eod_flag), .led_n(led_n)
  );

  initial begin
    forever begin
      repeat (9) @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  end

  always @(negedge clk) begin
    if (sb.size() > 0) begin
      sb_item_t it;
      it = sb.pop_front();
      n_vec++;
      if (led_n !== it.exp) begin
        n_bad++;
        $display("FAIL %s: led_n=%b expected %b", it.tag, led_n, it.exp);
      end
    end
  end

  task automatic expect_led(input logic [4:0] e, input string tag);
    @(posedge clk);
    sb.push_back('{exp: e, tag: tag});
    @(negedge clk);
    #1;
  endtask

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      while (!tick) @(posedge clk);
    end
    @(negedge clk);
  endtask

  task automatic press();
    @(negedge clk);
    btn_n = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic release_btn();
    @(negedge clk);
    btn_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    expect_led(5'b11111, "R4 reset dark");
    wait_ticks(3);
    expect_led(5'b11111, "R4 no press stays dark");

    press();
    expect_led(5'b11000, "R2 50pct of 5 lights 3");
    soc_rel = 7'd0;   expect_led(5'b11111, "R2 0pct lights none");
    soc_rel = 7'd1;   expect_led(5'b11110, "R2 1pct lights one");
    soc_rel = 7'd20;  expect_led(5'b11110, "R2 20pct lights one");
    soc_rel = 7'd21;  expect_led(5'b11100, "R2 21pct lights two");
    soc_rel = 7'd100; expect_led(5'b00000, "R2 100pct lights all");
    soc_rel = 7'd120; expect_led(5'b00000, "R9 over 100 clamps");
    use_abs = 1'b1; soc_abs = 7'd40;
    expect_led(5'b11100, "R3 absolute source chosen");
    seg_cfg = 2'b01; soc_abs = 7'd100;
    expect_led(5'b10000, "R1 R10 four segment bar");
    seg_cfg = 2'b00; soc_abs = 7'd34;
    expect_led(5'b11100, "R1 three segments 34pct");
    soc_abs = 7'd33;
    expect_led(5'b11110, "R1 three segments 33pct");
    use_abs = 1'b0; seg_cfg = 2'b10; soc_rel = 7'd50;

    wait_ticks(20);
    release_btn();
    press();
    wait_ticks(6);
    expect_led(5'b11000, "R5 still lit inside window");
    wait_ticks(6);
    expect_led(5'b11111, "R6 second press did not extend window");
    wait_ticks(3);
    expect_led(5'b11111, "R6 held low does not rearm");
    release_btn();
    press();
    expect_led(5'b11000, "R6 rearmed after release");
    wait_ticks(34);
    expect_led(5'b11111, "R5 window ends");
    release_btn();

    cap_alarm = 1'b1;
    press();
    expect_led(5'b11000, "R7 flash starts lit");
    wait_ticks(5);
    expect_led(5'b11111, "R7 flash dark half");
    wait_ticks(4);
    expect_led(5'b11000, "R7 flash lit again");
    wait_ticks(30);
    release_btn();
    cap_alarm = 1'b0;

    eod_flag = 1'b1;
    press();
    expect_led(5'b11111, "R8 end of discharge blanks");
    wait_ticks(2);
    expect_led(5'b11111, "R8 stays blank");

    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run hung, actual running expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule